// File: doc/BRIEF.md
# Latched-Input Parallel-to-Serial Shift Register

This block turns a parallel word into a serial bit stream. It has two registers in a row. A holding register captures the parallel word on the rising edge of its own capture clock. A shift register sits behind it and runs on a separate shift clock. A mode input chooses what the shift register does on each shift clock rising edge. With mode low, it copies the held word. With mode high, it shifts one place, taking a new bit from the serial input. The serial output comes straight from the last shift stage.

Parallel bit 0 feeds the first shift stage and the top bit feeds the last stage, so the top bit of a loaded word leaves first. An active-low reset clears the shift stages at once, without waiting for a clock edge. It never touches the holding register, so a word captured before a reset can still be loaded after it. The reset is released in step with the shift clock through a short synchronizer, which makes the first operative edge after reset well defined. Because the capture and shift clocks are independent, a new word can be captured while an earlier one is still being shifted out.

Top module: `pisr_latched_shifter`

## Requirements
- R1: The holding register takes the value of `par_in` on each rising edge of `cap_clk` and keeps it until the next such edge; changes of `par_in` between those edges have no effect.
- R2: On a rising edge of `shf_clk` with `mode_shift` low (0 = load), shift stage i takes held bit i. `ser_out` then shows held bit WIDTH-1 (the top bit).
- R3: On a rising edge of `shf_clk` with `mode_shift` high (1 = shift), stage 0 takes `ser_in` and stage i takes stage i-1. After a load, `ser_out` therefore shows held bits WIDTH-1 down to 0 on successive edges, followed by the `ser_in` bits in the order they were applied, each one WIDTH-1 edges after it entered.
- R4: While `mode_shift` is low, the value of `ser_in` has no effect on any shift stage.
- R5: While `rst_n` is low, all shift stages are zero, and `ser_out` is 0 without waiting for any clock edge.
- R6: A reset leaves the holding register unchanged, so a load after reset, with no capture in between, delivers the word captured before the reset.
- R7: After `rst_n` rises, the shift register stays cleared through the first RST_SYNC_STAGES rising edges of `shf_clk` (default 2). It acts normally from the next edge on.
- R8: A capture while `mode_shift` is high does not disturb a word already being shifted out. The new word appears only at the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Capture clock for the holding register |
| par_in | input | WIDTH | Parallel word; bit 0 goes to the first shift stage |
| shf_clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset of the shift stages |
| mode_shift | input | 1 | 0 = load from holding register, 1 = shift serially |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Last shift stage |

## Verification
The load assertion compares the shift stages with the holding register as it was sampled at the previous shift edge. It therefore assumes that `cap_clk` never rises close to a shift clock edge that performs a load. The bench meets this by pulsing `cap_clk` only in the low phase of `shf_clk`, well clear of any rising edge. The capture assertion assumes that only `cap_clk` edges change the holding register. The reset assertions assume that `rst_n` is driven low from time zero and changes only between shift edges. The bench drives all inputs at falling edges of `shf_clk` and samples `ser_out` there.

// File: rtl/pisr_pkg.sv
package pisr_pkg;

   typedef enum logic {
      MODE_LOAD  = 1'b0,
      MODE_SHIFT = 1'b1
   } shf_mode_e;

endpackage

// File: rtl/pisr_hold_reg.sv
module pisr_hold_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   // Deliberately no reset: the held word survives any shift-side reset.
   always_ff @(posedge clk) begin
      q <= d;
   end

endmodule

// File: rtl/pisr_rst_sync.sv
module pisr_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);

   logic [STAGES-1:0] sync_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) sync_q <= 1'b0;
            else         sync_q <= 1'b1;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) sync_q <= '0;
            else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
         end
      end
   endgenerate

   assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/pisr_shift_chain.sv
module pisr_shift_chain
   import pisr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  shf_mode_e        mode,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] load_word,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] feed;
   logic [WIDTH-1:0] nxt;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign feed[i] = ser_in;
         end else begin : g_body
            assign feed[i] = q[i-1];
         end
         assign nxt[i] = (mode == MODE_SHIFT) ? feed[i] : load_word[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

endmodule

// File: rtl/pisr_latched_shifter.sv
module pisr_latched_shifter
   import pisr_pkg::*;
#(
   parameter int WIDTH           = 8,
   parameter int RST_SYNC_STAGES = 2
) (
   input  logic             cap_clk,
   input  logic [WIDTH-1:0] par_in,
   input  logic             shf_clk,
   input  logic             rst_n,
   input  logic             mode_shift,
   input  logic             ser_in,
   output logic             ser_out
);

   localparam int LAST = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("pisr_latched_shifter: WIDTH must be at least 2");
      end
      if (RST_SYNC_STAGES < 1) begin : g_bad_sync
         $error("pisr_latched_shifter: RST_SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] hold_q;
   logic [WIDTH-1:0] chain_q;
   logic             rst_int_n;

   pisr_hold_reg #(.WIDTH(WIDTH)) u_hold (
      .clk (cap_clk),
      .d   (par_in),
      .q   (hold_q)
   );

   pisr_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rsync (
      .clk    (shf_clk),
      .arst_n (rst_n),
      .srst_n (rst_int_n)
   );

   pisr_shift_chain #(.WIDTH(WIDTH)) u_chain (
      .clk       (shf_clk),
      .rst_n     (rst_int_n),
      .mode      (shf_mode_e'(mode_shift)),
      .ser_in    (ser_in),
      .load_word (hold_q),
      .q         (chain_q)
   );

   assign ser_out = chain_q[LAST];

endmodule

// File: rtl/pisr_latched_shifter_chk.sv
module pisr_latched_shifter_chk #(
   parameter int WIDTH = 8
) (
   input logic             cap_clk,
   input logic             shf_clk,
   input logic             rst_n,
   input logic             rst_int_n,
   input logic             mode_shift,
   input logic             ser_in,
   input logic [WIDTH-1:0] par_in,
   input logic [WIDTH-1:0] hold_q,
   input logic [WIDTH-1:0] chain_q
);

   assert_capture_R1: assert property (@(posedge cap_clk)
      1'b1 |=> hold_q == $past(par_in));

   assert_load_R2: assert property (@(posedge shf_clk) disable iff (!rst_int_n)
      !mode_shift |=> chain_q == $past(hold_q));

   assert_shift_R3: assert property (@(posedge shf_clk) disable iff (!rst_int_n)
      mode_shift |=> chain_q == {$past(chain_q[WIDTH-2:0]), $past(ser_in)});

   assert_cleared_R5: assert property (@(posedge shf_clk)
      !rst_n |-> chain_q == '0);

   assert_sync_release_R7: assert property (@(posedge shf_clk) disable iff (!rst_n)
      $rose(rst_n) |=> chain_q == '0);

endmodule

bind pisr_latched_shifter pisr_latched_shifter_chk #(.WIDTH(WIDTH)) u_chk (
   .cap_clk    (cap_clk),
   .shf_clk    (shf_clk),
   .rst_n      (rst_n),
   .rst_int_n  (rst_int_n),
   .mode_shift (mode_shift),
   .ser_in     (ser_in),
   .par_in     (par_in),
   .hold_q     (hold_q),
   .chain_q    (chain_q)
);

// File: tb/pisr_latched_shifter_bench.sv
module pisr_latched_shifter_bench;

   localparam int W = 8;

   logic         cap_clk = 1'b0;
   logic [W-1:0] par_in = '0;
   logic         shf_clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode_shift = 1'b0;
   logic         ser_in = 1'b0;
   logic         ser_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   pisr_latched_shifter #(.WIDTH(W), .RST_SYNC_STAGES(2)) u_pisr_latched_shifter (
      .cap_clk    (cap_clk),
      .par_in     (par_in),
      .shf_clk    (shf_clk),
      .rst_n      (rst_n),
      .mode_shift (mode_shift),
      .ser_in     (ser_in),
      .ser_out    (ser_out)
   );

   always #10 shf_clk = ~shf_clk;

   task automatic check(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: ser_out=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // one shift clock rising edge, returning at the following falling edge
   task automatic step();
      @(posedge shf_clk);
      @(negedge shf_clk);
   endtask

   // capture pulse in the low phase of shf_clk, away from its rising edges
   task automatic capture(input logic [W-1:0] w);
      par_in = w;
      #2 cap_clk = 1'b1;
      #3 cap_clk = 1'b0;
      #1;
   endtask

   task automatic reset_release_check(input logic top_bit);
      mode_shift = 1'b0;
      rst_n = 1'b1;
      step(); check(ser_out, 1'b0, "R7 edge1");
      step(); check(ser_out, 1'b0, "R7 edge2");
      step(); check(ser_out, top_bit, "R7 edge3 load");
   endtask

   task automatic t_reset_state();
      @(negedge shf_clk);
      check(ser_out, 1'b0, "R5 initial");
      capture(8'h81);
      reset_release_check(1'b1);
   endtask

   task automatic t_load_shift(input logic [W-1:0] w, input logic [W-1:0] s);
      capture(w);
      mode_shift = 1'b0;
      step(); check(ser_out, w[W-1], "R2 first bit");
      mode_shift = 1'b1;
      for (int k = 1; k <= 15; k++) begin
         ser_in = s[(k-1) % W];
         step();
         if (k <= 7) check(ser_out, w[W-1-k], "R3 word bit");
         else        check(ser_out, s[k-8], "R3 serial-in bit");
      end
   endtask

   task automatic t_mode_low_ignores(input logic [W-1:0] w);
      capture(w);
      mode_shift = 1'b0;
      for (int k = 0; k < 4; k++) begin
         ser_in = k[0];
         step(); check(ser_out, w[W-1], "R4 hold while low");
      end
      mode_shift = 1'b1;
      ser_in = 1'b0;
      for (int k = 1; k < W; k++) begin
         step(); check(ser_out, w[W-1-k], "R4 stages intact");
      end
   endtask

   task automatic t_async_reset();
      capture(8'hFF);
      mode_shift = 1'b0;
      step();
      mode_shift = 1'b1;
      ser_in = 1'b1;
      step();
      #3 rst_n = 1'b0;
      #1 check(ser_out, 1'b0, "R5 async clear");
      @(negedge shf_clk);
      rst_n = 1'b1;
      step(); check(ser_out, 1'b0, "R7 hold edge1");
      step(); check(ser_out, 1'b0, "R7 hold edge2");
      ser_in = 1'b0;
      for (int k = 0; k < W; k++) begin
         step(); check(ser_out, 1'b0, "R5 all stages zero");
      end
   endtask

   task automatic t_reset_keeps_hold(input logic [W-1:0] w);
      capture(w);
      mode_shift = 1'b0;
      step();
      mode_shift = 1'b1;
      step(); step();
      rst_n = 1'b0;
      step(); check(ser_out, 1'b0, "R5 in reset");
      reset_release_check(w[W-1]);
      mode_shift = 1'b1;
      for (int k = 1; k < W; k++) begin
         step(); check(ser_out, w[W-1-k], "R6 held word after reset");
      end
   endtask

   task automatic t_capture_mid_shift(input logic [W-1:0] w1, input logic [W-1:0] w2);
      capture(w1);
      mode_shift = 1'b0;
      step(); check(ser_out, w1[W-1], "R2 load w1");
      mode_shift = 1'b1;
      for (int k = 1; k <= 3; k++) begin
         step(); check(ser_out, w1[W-1-k], "R8 before capture");
      end
      capture(w2);
      par_in = ~w2;
      for (int k = 4; k < W; k++) begin
         step(); check(ser_out, w1[W-1-k], "R8 after capture");
      end
      mode_shift = 1'b0;
      step(); check(ser_out, w2[W-1], "R1 new word top");
      mode_shift = 1'b1;
      for (int k = 1; k < W; k++) begin
         step(); check(ser_out, w2[W-1-k], "R1 no capture without edge");
      end
   endtask

   initial begin
      t_reset_state();
      t_load_shift(8'h5A, 8'hB4);
      t_load_shift(8'hC3, 8'h0F);
      t_mode_low_ignores(8'h6D);
      t_async_reset();
      t_reset_keeps_hold(8'hA5);
      t_capture_mid_shift(8'h39, 8'h80);
      t_load_shift(8'h01, 8'hFF);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule